// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock with Alarm Interrupt

The block keeps a free-running 32-bit count of seconds. A prescaler divides the system clock by `CLK_PER_SEC` to produce one tick per second. A programmable alarm value is compared against that count, and a one-bit mask gates the resulting interrupt onto the `irq` pin.

Software talks to the block over a plain register bus. The bus has a byte address, a write strobe and a read strobe, and read data is returned one cycle after the read strobe. Four kinds of configuration write are posted rather than applied at once:

- loading the count
- setting the alarm
- setting the mask
- acknowledging the interrupt

Each of these takes `SYNC_DELAY` clock cycles to complete. While it is pending, its own busy bit in the status register is set. This models a clock that lives in a slow, separate domain. Software polls the status bit before it relies on the new value.

Top module: `secs_rtc`

Register map (byte offsets):

- 0x00: live count, read-only.
- 0x04: alarm.
- 0x08: load.
- 0x0C: mask, bit 0.
- 0x10: masked status on read; acknowledge on write.
- 0x14: busy flags, read-only.

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq` is 0.
- R2: The live count at offset 0x00 increases by exactly one every `CLK_PER_SEC` clock cycles. Writes to offsets 0x00 and 0x14 change nothing.
- R3: A write to offset 0x08 is reflected at once when offset 0x08 is read back. The live count takes the written value `SYNC_DELAY` cycles after the write and keeps counting from it.
- R4: A write to offset 0x04 becomes the alarm `SYNC_DELAY` cycles after the write. Reading offset 0x04 returns the alarm currently in force.
- R5: The interrupt becomes active in the cycle after the live count changes from not greater to strictly greater than the alarm, with the comparison made as unsigned. It stays active until it is acknowledged.
- R6: Bit 0 of a write to offset 0x0C becomes the mask `SYNC_DELAY` cycles after the write. `irq` equals active AND mask. Bit 0 of offset 0x10 reads the same value.
- R7: A write to offset 0x10 with bit 0 set clears the active interrupt `SYNC_DELAY` cycles later. A write to offset 0x10 with bit 0 clear has no effect.
- R8: Offset 0x14 bit 0 flags a pending load, bit 1 a pending alarm update, bit 2 a pending acknowledge and bit 3 a pending mask update. Each bit is high for exactly `SYNC_DELAY` cycles after the last write of its kind.
- R9: A second write of the same kind while that kind is pending restarts its delay, and only the newest value is applied.
- R10: `bus_rdata` is the value of the addressed register one cycle after `bus_re`, and 0 in any cycle that follows no read. Unused bits and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check four properties on every cycle:

- The live count only steps by one, unless a load was pending.
- The interrupt becomes active only after the count has exceeded the alarm.
- The interrupt clears only after a pending acknowledge.
- A write of each kind raises its busy flag on the next cycle.

The exact arrival cycle of each posted value, the restart of a delay by a second write, and the unsigned comparison near the top of the range cannot be shown by those properties. The bench scenarios show them by comparing read data and `irq` against a reference model on every clock.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  localparam int N_CH     = 4;
  localparam int CH_LOAD  = 0;
  localparam int CH_ALARM = 1;
  localparam int CH_ACK   = 2;
  localparam int CH_MASK  = 3;

  localparam logic [7:0] OFS_TIME  = 8'h00;
  localparam logic [7:0] OFS_ALARM = 8'h04;
  localparam logic [7:0] OFS_LOAD  = 8'h08;
  localparam logic [7:0] OFS_MASK  = 8'h0C;
  localparam logic [7:0] OFS_ISTAT = 8'h10;
  localparam logic [7:0] OFS_BUSY  = 8'h14;

  // byte offset that starts a posted write of channel i
  function automatic logic [7:0] ch_offset(int i);
    case (i)
      CH_LOAD:  return OFS_LOAD;
      CH_ALARM: return OFS_ALARM;
      CH_ACK:   return OFS_ISTAT;
      default:  return OFS_MASK;
    endcase
  endfunction
endpackage

// File: rtl/secs_rtc_prescale.sv
module secs_rtc_prescale #(
  parameter int CLK_PER_SEC = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PRE_W = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_PER_SEC - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)               pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == LAST);
endmodule

// File: rtl/secs_rtc_posted.sv
module secs_rtc_posted #(
  parameter int W     = 32,
  parameter int DELAY = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic         busy,
  output logic         apply
);
  localparam int DLY_W = $clog2(DELAY + 1);
  localparam logic [DLY_W-1:0] FULL = DLY_W'(DELAY);

  logic [DLY_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      shadow <= '0;
    end else if (wr) begin
      rem_q  <= FULL;          // a new write restarts the wait
      shadow <= wdata;
    end else if (rem_q != '0) begin
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign busy  = (rem_q != '0);
  assign apply = (rem_q == DLY_W'(1)) && !wr;
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int CLK_PER_SEC = 1000,
  parameter int SYNC_DELAY  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(OFS_TIME);
  localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(OFS_ALARM);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT);
  localparam logic [ADDR_W-1:0] A_BUSY  = ADDR_W'(OFS_BUSY);

  logic              tick;
  logic [N_CH-1:0]   busy, apply;
  logic [DATA_W-1:0] ld_sh, al_sh;
  logic              mk_sh, ak_sh;

  logic [DATA_W-1:0] cnt_q, alarm_q;
  logic              mask_q, active_q, gt_q;
  logic              gt;

  secs_rtc_prescale #(.CLK_PER_SEC(CLK_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int CW = (i == CH_LOAD || i == CH_ALARM) ? DATA_W : 1;
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(ch_offset(i));
    logic          wr_i;
    logic [CW-1:0] sh_i;

    // an acknowledge only starts when bit 0 is set
    if (i == CH_ACK) begin : g_ackq
      assign wr_i = bus_we && (bus_addr == CA) && bus_wdata[0];
    end else begin : g_plain
      assign wr_i = bus_we && (bus_addr == CA);
    end

    secs_rtc_posted #(.W(CW), .DELAY(SYNC_DELAY)) u_post (
      .clk(clk), .rst(rst), .wr(wr_i), .wdata(bus_wdata[CW-1:0]),
      .shadow(sh_i), .busy(busy[i]), .apply(apply[i])
    );

    if (i == CH_LOAD) begin : g_ld
      assign ld_sh = sh_i;
    end else if (i == CH_ALARM) begin : g_al
      assign al_sh = sh_i;
    end else if (i == CH_ACK) begin : g_ak
      assign ak_sh = sh_i[0];
    end else begin : g_mk
      assign mk_sh = sh_i[0];
    end
  end

  assign gt = (cnt_q > alarm_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      alarm_q  <= '0;
      mask_q   <= 1'b0;
      active_q <= 1'b0;
      gt_q     <= 1'b0;
    end else begin
      if (apply[CH_LOAD])  cnt_q <= ld_sh;
      else if (tick)       cnt_q <= cnt_q + 1'b1;
      if (apply[CH_ALARM]) alarm_q <= al_sh;
      if (apply[CH_MASK])  mask_q <= mk_sh;
      if (apply[CH_ACK] && ak_sh) active_q <= 1'b0;
      else if (gt && !gt_q)       active_q <= 1'b1;
      gt_q <= gt;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_TIME:  rd_mux = cnt_q;
      A_ALARM: rd_mux = alarm_q;
      A_LOAD:  rd_mux = ld_sh;
      A_MASK:  rd_mux = DATA_W'(mask_q);
      A_ISTAT: rd_mux = DATA_W'(active_q & mask_q);
      A_BUSY:  rd_mux = DATA_W'(busy);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_re ? rd_mux : '0;
  end

  assign irq = active_q & mask_q;
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk
  import secs_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] alarm,
  input logic              active,
  input logic [N_CH-1:0]   busy
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) && !$past(busy[CH_LOAD]) |-> cnt == $past(cnt) + DATA_W'(1));

  // R5
  alarm_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(cnt) > $past(alarm));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(busy[CH_ACK]));

  // R8
  load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == ADDR_W'(OFS_LOAD) |=> busy[CH_LOAD]);

  // R8
  alarm_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == ADDR_W'(OFS_ALARM) |=> busy[CH_ALARM]);

  // R8
  mask_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == ADDR_W'(OFS_MASK) |=> busy[CH_MASK]);

  // R7
  ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == ADDR_W'(OFS_ISTAT) && bus_wdata[0] |=> busy[CH_ACK]);
endmodule

bind secs_rtc secs_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt(cnt_q), .alarm(alarm_q),
  .active(active_q), .busy(busy)
);

// File: tb/secs_rtc_bench.sv
module secs_rtc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPS  = 5;
  localparam int SYNC = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  secs_rtc #(.DATA_W(32), .ADDR_W(5), .CLK_PER_SEC(CPS), .SYNC_DELAY(SYNC)) u_secs_rtc (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model: seconds clock with posted writes, kept as plain integers
  int unsigned m_phase, m_time, m_alarm, m_mask, m_act, m_was_gt, m_rd;
  int unsigned m_wait[4];
  int unsigned m_new[4];
  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";

  always @(posedge clk) begin
    int unsigned rd_v, n_time, n_alarm, n_mask, n_act;
    bit gt, fire[4];
    if (rst) begin
      m_phase = 0; m_time = 0; m_alarm = 0; m_mask = 0; m_act = 0; m_was_gt = 0; m_rd = 0;
      for (int k = 0; k < 4; k++) begin m_wait[k] = 0; m_new[k] = 0; end
    end else begin
      case (bus_addr)
        5'h00: rd_v = m_time;
        5'h04: rd_v = m_alarm;
        5'h08: rd_v = m_new[0];
        5'h0C: rd_v = m_mask;
        5'h10: rd_v = m_act & m_mask;
        5'h14: rd_v = {28'd0, m_wait[3] != 0, m_wait[2] != 0, m_wait[1] != 0, m_wait[0] != 0};
        default: rd_v = 0;
      endcase
      gt = m_time > m_alarm;
      n_time = m_time; n_alarm = m_alarm; n_mask = m_mask; n_act = m_act;
      for (int k = 0; k < 4; k++) fire[k] = (m_wait[k] == 1);
      if (bus_we) begin
        int ch;
        ch = -1;
        if (bus_addr == 5'h08) ch = 0;
        if (bus_addr == 5'h04) ch = 1;
        if (bus_addr == 5'h10 && bus_wdata[0]) ch = 2;
        if (bus_addr == 5'h0C) ch = 3;
        if (ch >= 0) begin fire[ch] = 0; m_wait[ch] = SYNC + 1; m_new[ch] = bus_wdata; end
      end
      if (fire[0]) n_time = m_new[0];
      else if (m_phase == CPS - 1) n_time = m_time + 1;
      if (fire[1]) n_alarm = m_new[1];
      if (fire[3]) n_mask = m_new[3] & 1;
      if (fire[2]) n_act = 0;
      else if (gt && !m_was_gt) n_act = 1;
      m_was_gt = gt;
      m_phase = (m_phase == CPS - 1) ? 0 : m_phase + 1;
      for (int k = 0; k < 4; k++) if (m_wait[k] != 0) m_wait[k]--;
      m_time = n_time; m_alarm = n_alarm; m_mask = n_mask; m_act = n_act;
      m_rd = bus_re ? rd_v : 0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h at cycle %0d", tag, bus_rdata, m_rd, cycles);
      end
      vectors++;
      if (irq !== (m_act[0] & m_mask[0])) begin
        errors++;
        $display("FAIL R6: irq actual %b expected %b at cycle %0d", irq, m_act[0] & m_mask[0], cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic op(input bit we, input bit re, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
  endtask

  task automatic poll(input logic [4:0] a, input int n);
    for (int i = 0; i < n; i++) op(0, 1, a, 0);
  endtask

  task automatic poll_all(input int n);
    for (int i = 0; i < n; i++) op(0, 1, 5'(4 * (i % 6)), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";  poll_all(7);                       // reset values read 0
    tag = "R2";  poll(5'h00, 30);                   // one step per CPS cycles
    op(1, 0, 5'h00, 32'hDEAD); op(1, 0, 5'h14, 32'hF); poll_all(12);
    tag = "R3";  op(1, 0, 5'h08, 32'd1000); op(0, 1, 5'h08, 0);
    poll(5'h00, 15);
    tag = "R8";  op(1, 0, 5'h04, 32'd1010); poll(5'h14, 10);
    tag = "R9";  op(1, 0, 5'h08, 32'd50); poll(5'h14, 3);
    op(1, 0, 5'h08, 32'd70); poll(5'h00, 2); poll(5'h14, 8); poll(5'h00, 12);
    tag = "R4";  op(1, 0, 5'h04, 32'd74); poll(5'h04, 10);
    tag = "R6";  op(1, 0, 5'h0C, 32'hFFFF_FFF1); poll(5'h0C, 10);
    tag = "R5";  poll(5'h10, 40);                   // count passes 74
    tag = "R7";  op(1, 0, 5'h10, 32'h2); poll(5'h14, 10);   // bit0 clear: nothing
    op(1, 0, 5'h10, 32'h1); poll(5'h10, 10);
    tag = "R6";  op(1, 0, 5'h0C, 0); poll(5'h0C, 10);
    tag = "R5";  op(1, 0, 5'h04, 32'h7FFF_FFFF); op(1, 0, 5'h08, 32'h7FFF_FFFE);
    op(1, 0, 5'h0C, 1); poll(5'h10, 25);            // unsigned pass at 0x80000000
    op(1, 0, 5'h10, 1); poll(5'h10, 20);
    tag = "R10"; poll(5'h18, 3); poll(5'h1C, 3);
    for (int i = 0; i < 5; i++) op(0, 0, 5'h00, 0);
    poll_all(12);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule